// File: doc/BRIEF.md
# Boundary Scan Chain for Bidirectional Pins

This block is the boundary register of a test access port for a set of bidirectional pins. Each pin has a data cell, and right above it in the chain sits a control cell. When the control cell's update latch holds 1, the pin's driver is switched off. Chosen pins also carry two pin-less internal cells above their control cell. A run of internal cells sits at the serial-output end. The TAP controller supplies the capture, shift and update strobes, the external-test select and the high-impedance force. Its state machine lies outside this block.

Each cell has a shift stage and an update latch. A capture strobe loads the shift stages in parallel, a shift strobe moves them one place toward `tdo`, and an update strobe copies them into the latches. In external-test mode the latches drive the pads. In any other mode the core's own output and enable pass straight through. The pad level always reaches the core.

Top module: `bscan_chain`

## Requirements
- R1: The cells are numbered from `tdo` (cell 0) up to `tdi` (cell LEN-1). A shift strobe moves every shift stage one cell down, and `tdi` enters cell LEN-1. `tdo` shows cell 0. With the defaults LEN is 17. Pin p's control and data cells are (14,13), (10,9), (8,7) and (6,5) for p = 0..3. Pins 0 and 1 own internal cells 16,15 and 12,11, and cells 4..0 form the tail.
- R2: On a capture strobe, a data cell loads the level on its pin's `pad_in`, whether or not the pin is being driven.
- R3: On a capture strobe, every control cell and internal cell loads the current content of its own update latch.
- R4: The update latches change only on an update strobe. Shifting or capturing without one leaves the pads unchanged.
- R5: Reset loads both shift stages and latches with safe values: 1 in every control cell and tail cell, 0 elsewhere. In external-test mode after reset, every `pad_oe` bit is therefore 0.
- R6: With `extest`=1 and `highz`=0, `pad_out[p]` equals pin p's data-cell latch. `pad_oe[p]` is 1 exactly when pin p's control-cell latch is 0.
- R7: With `extest`=0 and `highz`=0, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R8: While `highz`=1, every `pad_oe` bit is 0, whatever the latch contents and mode.
- R9: `core_in` always equals `pad_in`.
- R10: A capture strobe takes precedence over a shift strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Latch update strobe |
| extest | input | 1 | External-test mode select |
| highz | input | 1 | Force all pad drivers off |
| core_out | input | NPINS | Core output value per pin |
| core_oe | input | NPINS | Core output enable per pin |
| pad_in | input | NPINS | Level seen on each pad |
| tdo | output | 1 | Serial data out |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Pad driver enable, 1 = drive |
| core_in | output | NPINS | Pad level returned to the core |

## Verification
A wrong latch or shift-stage bit reaches the ports by two routes. It shows on `pad_out` or `pad_oe` as soon as external-test mode is on. It also appears on `tdo` after a capture, one cycle per cell of distance from cell 0. A corrupted control cell therefore shows up at once as a pin that drives when it should float. A misordered cell only shows as a shifted bit pattern, within one full chain length of shifting. Known capture patterns are read out in full and checked bit by bit, so the order of the cells is checked along with their contents.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int NPINS = 4,
  parameter logic [NPINS-1:0] XMASK = 4'b0011,
  parameter int NTAIL = 5
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             extest,
  input  logic             highz,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] pad_in,
  output logic             tdo,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] core_in
);

  function automatic int above(input int p);
    int s = 0;
    for (int j = 0; j < p; j++) s += XMASK[j] ? 4 : 2;
    return s;
  endfunction

  localparam int LEN = NTAIL + above(NPINS);

  function automatic int ctl_at(input int p);
    return LEN - 1 - above(p) - (XMASK[p] ? 2 : 0);
  endfunction

  function automatic logic [LEN-1:0] safe_vec();
    logic [LEN-1:0] v = '0;
    for (int k = 0; k < NTAIL; k++) v[k] = 1'b1;
    for (int p = 0; p < NPINS; p++) v[ctl_at(p)] = 1'b1;
    return v;
  endfunction

  localparam logic [LEN-1:0] SAFE = safe_vec();

  logic [LEN-1:0] sr, up, cap;

  always_comb begin
    cap = up;
    for (int p = 0; p < NPINS; p++) cap[ctl_at(p) - 1] = pad_in[p];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= SAFE;
      up <= SAFE;
    end else begin
      if (capture_dr)    sr <= cap;
      else if (shift_dr) sr <= {tdi, sr[LEN-1:1]};
      if (update_dr)     up <= sr;
    end
  end

  assign tdo     = sr[0];
  assign core_in = pad_in;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int C = ctl_at(p);
    assign pad_out[p] = extest ? up[C-1] : core_out[p];
    assign pad_oe[p]  = !highz && (extest ? !up[C] : core_oe[p]);
  end

endmodule

module bscan_chain_chk #(
  parameter int NPINS = 4,
  parameter int LEN = 17
) (
  input logic             tck,
  input logic             trst_n,
  input logic             capture_dr,
  input logic             shift_dr,
  input logic             update_dr,
  input logic             highz,
  input logic             tdo,
  input logic [LEN-1:0]   sr,
  input logic [LEN-1:0]   up,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] core_in
);

  a_r1_shift_moves: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr) |=> (tdo == $past(sr[1])));

  a_r4_latch_holds: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(up));

  a_r8_highz_off: assert property (@(posedge tck) disable iff (!trst_n)
    highz |-> (pad_oe == '0));

  a_r9_core_sees_pad: assert property (@(posedge tck) disable iff (!trst_n)
    core_in == pad_in);

endmodule

bind bscan_chain bscan_chain_chk #(.NPINS(NPINS), .LEN(LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .highz(highz), .tdo(tdo), .sr(sr), .up(up),
  .pad_in(pad_in), .pad_oe(pad_oe), .core_in(core_in)
);

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int PERIOD = 10;
  localparam int N = 4;
  localparam int L = 17;

  logic tck = 0, trst_n = 0, tdi = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic extest = 0, highz = 0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic tdo;
  logic [N-1:0] pad_out, pad_oe, core_in;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic  exp_q[$];
  string tag_q[$];

  bscan_chain u0 (.*);

  always #(PERIOD/2) tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected serial bit for every shift cycle
  initial forever begin
    @(negedge tck);
    #(PERIOD/4);
    if (shift_dr && exp_q.size() > 0) chk(tag_q.pop_front(), 32'(tdo), 32'(exp_q.pop_front()));
  end

  // driver: shifts v in, queues the bits expected out
  task automatic shift_vec(input logic [L-1:0] v, input logic [L-1:0] expect_out, input string req);
    for (int k = 0; k < L; k++) begin
      @(negedge tck);
      tdi = v[k];
      shift_dr = 1;
      exp_q.push_back(expect_out[k]);
      tag_q.push_back(req);
    end
    @(negedge tck);
    shift_dr = 0;
  endtask

  task automatic pulse_capture();
    @(negedge tck); capture_dr = 1;
    @(negedge tck); capture_dr = 0;
  endtask

  task automatic pulse_update();
    @(negedge tck); update_dr = 1;
    @(negedge tck); update_dr = 0;
  endtask

  localparam logic [L-1:0] SAFE = 17'b0_0100_0101_0101_1111;
  localparam logic [L-1:0] V    = 17'b1_0010_1110_0010_1011;
  localparam logic [L-1:0] CAP2 = 17'b1_0010_1100_1000_1011;

  initial begin
    core_out = 4'b1100; core_oe = 4'b0011; pad_in = 4'b0110;
    #(PERIOD*3);
    @(negedge tck); trst_n = 1;
    #1;
    chk("R7 reset passthrough out", 32'(pad_out), 32'(4'b1100));
    chk("R7 reset passthrough oe", 32'(pad_oe), 32'(4'b0011));
    chk("R9 core_in", 32'(core_in), 32'(4'b0110));
    chk("R1 tdo is cell0 after reset", 32'(tdo), 32'(1'b1));

    extest = 1; #1;
    chk("R5 safe oe in extest", 32'(pad_oe), 32'(4'b0000));
    chk("R5 safe data latches", 32'(pad_out), 32'(4'b0000));

    pad_in = 4'b1010;
    pulse_capture();
    shift_vec(V, SAFE | 17'h00220, "R2/R3/R1 first capture readout");
    #1;
    chk("R4 no update yet oe", 32'(pad_oe), 32'(4'b0000));
    pulse_update(); #1;
    chk("R6 pad_out from latches", 32'(pad_out), 32'(4'b1011));
    chk("R6 pad_oe from control", 32'(pad_oe), 32'(4'b1101));

    highz = 1; #1;
    chk("R8 highz oe", 32'(pad_oe), 32'(4'b0000));
    chk("R8 highz keeps data", 32'(pad_out), 32'(4'b1011));
    highz = 0; #1;
    chk("R8 release restores oe", 32'(pad_oe), 32'(4'b1101));

    pad_in = 4'b0101;
    chk("R9 core_in in extest", 32'(core_in), 32'(4'b0101));
    // R10: both strobes in one cycle; capture must win
    @(negedge tck); capture_dr = 1; shift_dr = 1; tdi = 0;
    @(negedge tck); capture_dr = 0; shift_dr = 0;
    #1;
    chk("R10 capture wins over shift", 32'(tdo), 32'(CAP2[0]));
    shift_vec('0, CAP2, "R2/R3 second capture readout");
    #1;
    chk("R4 shift without update out", 32'(pad_out), 32'(4'b1011));
    chk("R4 shift without update oe", 32'(pad_oe), 32'(4'b1101));
    pulse_update(); #1;
    chk("R6 zero latches oe", 32'(pad_oe), 32'(4'b1111));
    chk("R6 zero latches out", 32'(pad_out), 32'(4'b0000));

    extest = 0; core_out = 4'b0110; core_oe = 4'b1001; #1;
    chk("R7 passthrough out", 32'(pad_out), 32'(4'b0110));
    chk("R7 passthrough oe", 32'(pad_oe), 32'(4'b1001));
    highz = 1; #1;
    chk("R8 highz outside extest", 32'(pad_oe), 32'(4'b0000));
    highz = 0;

    repeat (3) @(negedge tck);
    chk("R1 all queued bits consumed", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD*20000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule